// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register side of a system-control coprocessor. A processor core talks to it only through two kinds of transfer: a write that moves a core register into a coprocessor register, and a read that moves a coprocessor register back into a core register. Each transfer carries four selector fields: a primary opcode, a primary register number, a secondary register number and a secondary opcode. The bank decodes these fields to pick one of five entries.

Two of the entries are read-only and share primary register 0. The secondary opcode chooses between them: one gives the device identity and the other gives the cache geometry. The other entries are writable:

- a control word;
- a translation-table base;
- a domain access word holding sixteen two-bit fields.

The control word is decoded into enables and selects for the memory system. These cover translation, alignment checking, both caches, the write buffer, byte order, the two permission bits, the replacement policy, the exception vector base and the bus clocking mode. Software changes single control bits by a read, a modify and a write. For that to work, every implemented bit reads back exactly as it was written.

Top module: `sysctl_cop`

## Requirements
- R1: A transfer is decoded only when the primary opcode is 0 and the secondary register number is 0. The primary register must be 0 (secondary opcode 0 or 1) or be 1, 2 or 3 (secondary opcode 0). Any other valid transfer changes no state, gives no read strobe, and makes `undef_flag` high for exactly the one cycle after the request.
- R2: A read of primary register 0 returns 0x41129200 when the secondary opcode is 0. It returns 0x0D172172 when the secondary opcode is 1.
- R3: A write to either entry of primary register 0 is ignored: no register changes and no output changes. It raises `undef_flag` in the following cycle.
- R4: After a synchronous active-low reset, the control word, the table base and the domain word are all zero. All enables are then off, the byte order is little-endian, `vec_base` is 0x00000000 and `bus_mode` is 00.
- R5: Control word bits 0-3, 7-9, 12-14 and 30-31 are stored (mask 0xC000738F). All other bits ignore writes and read as zero. A read returns the last written value ANDed with that mask.
- R6: The control bits map to outputs as follows:
  - bit 0 to `mmu_en`, bit 1 to `align_chk_en`, bit 2 to `dcache_en`, bit 3 to `wbuf_en`;
  - bit 7 to `big_endian`, bit 8 to `perm_s`, bit 9 to `perm_r`;
  - bit 12 to `icache_en`, bit 14 to `rr_replace`;
  - bit 13 moves `vec_base` from 0x00000000 to 0xFFFF0000.
- R7: Control bits 31:30 give the bus mode, and `bus_mode` carries the same code: 00 fast, 01 synchronous, 11 asynchronous. While the field holds the reserved code 10, `bus_mode` keeps the last non-reserved value, and 10 never appears on it.
- R8: Primary register 2 stores all 32 written bits. They read back unchanged and drive `ttb_base`.
- R9: Primary register 3 stores all 32 written bits. They read back unchanged and drive `domain_acc`.
- R10: A write shows on the outputs and on read-back after the rising edge that samples the request. Read data and `rvalid` appear combinationally in the request cycle. `rvalid` stays low for writes, for idle cycles and for undecoded transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_valid | input | 1 | Transfer request this cycle |
| xfer_wr | input | 1 | 1 = core-to-coprocessor write, 0 = read |
| op1 | input | 3 | Primary opcode |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op2 | input | 3 | Secondary opcode |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (zero when not a valid read) |
| rvalid | output | 1 | Read data valid |
| undef_flag | output | 1 | One-cycle undefined-access pulse |
| mmu_en | output | 1 | Translation enable |
| align_chk_en | output | 1 | Alignment fault check enable |
| dcache_en | output | 1 | Data cache enable |
| wbuf_en | output | 1 | Write buffer enable |
| big_endian | output | 1 | Big-endian select |
| perm_s | output | 1 | System permission bit |
| perm_r | output | 1 | ROM permission bit |
| icache_en | output | 1 | Instruction cache enable |
| rr_replace | output | 1 | Round-robin (1) or random (0) replacement |
| vec_base | output | 32 | Exception vector base address |
| bus_mode | output | 2 | Bus clocking mode, never the reserved code |
| ttb_base | output | 32 | Translation table base |
| domain_acc | output | 32 | Domain access fields |

## Verification
A corrupted control, table-base or domain register shows on its decoded output in the cycle after the bad write. It also shows on the next read of that register, because read data comes straight from the stored value. A stale bus-mode hold register is hidden until software writes the reserved code; `bus_mode` then shows the wrong mode at once. A wrong undefined-access decision shows as a missing or extra `undef_flag` pulse in the cycle after the request, or as a missing or extra `rvalid` in the request cycle.

// File: rtl/sysctl_pkg.sv
// Shared types and constants of the system control coprocessor.
// Assumes a 32-bit core data path.
package sysctl_pkg;
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_ID    = 3'd1,
        SEL_CTYPE = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_TTB   = 3'd4,
        SEL_DAC   = 3'd5
    } reg_sel_e;

    // Control word bit positions that neighbouring logic decodes
    localparam int B_MMU   = 0;
    localparam int B_ALIGN = 1;
    localparam int B_DC    = 2;
    localparam int B_WB    = 3;
    localparam int B_BIG   = 7;
    localparam int B_S     = 8;
    localparam int B_R     = 9;
    localparam int B_IC    = 12;
    localparam int B_VEC   = 13;
    localparam int B_RR    = 14;
    localparam int B_MODE  = 30;

    localparam logic [1:0] MODE_RSVD = 2'b10;
endpackage

// File: rtl/sysctl_decode.sv
// Field decoder: maps the selector fields of one transfer to a register select.
// Assumes only primary opcode 0 and secondary register 0 are implemented.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output reg_sel_e   sel
);
    // Purpose: pick the addressed entry, SEL_NONE when not implemented
    always_comb begin
        sel = SEL_NONE;
        if (op1 == 3'd0 && crm == 4'd0) begin
            unique case (crn)
                4'd0:    sel = (op2 == 3'd0) ? SEL_ID :
                               (op2 == 3'd1) ? SEL_CTYPE : SEL_NONE;
                4'd1:    sel = (op2 == 3'd0) ? SEL_CTRL : SEL_NONE;
                4'd2:    sel = (op2 == 3'd0) ? SEL_TTB  : SEL_NONE;
                4'd3:    sel = (op2 == 3'd0) ? SEL_DAC  : SEL_NONE;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
// Writable storage: control word (masked), table base and domain word.
// Assumes wr_en is already qualified by a valid write request.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int          DW        = 32,
    parameter logic [31:0] CTRL_MASK = 32'hC000_738F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] ttb_q,
    output logic [DW-1:0] dac_q
);
    localparam logic [DW-1:0] MASK = DW'(CTRL_MASK);

    // Purpose: load the addressed writable register on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ttb_q  <= '0;
            dac_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) ctrl_q <= wdata & MASK;
            if (sel == SEL_TTB)  ttb_q  <= wdata;
            if (sel == SEL_DAC)  dac_q  <= wdata;
        end
    end

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~MASK) == '0);
    a_r8_ttb_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TTB) |=> ttb_q == $past(wdata));
    a_r3_ro_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_ID || sel == SEL_CTYPE))
        |=> ($stable(ctrl_q) && $stable(ttb_q) && $stable(dac_q)));
endmodule

// File: rtl/sysctl_ctrl_out.sv
// Control word decoder: drives the enables, vector base and bus mode.
// Assumes the control word has its reserved bits already cleared.
module sysctl_ctrl_out
    import sysctl_pkg::*;
#(
    parameter int          DW     = 32,
    parameter logic [31:0] VEC_HI = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctrl,
    output logic          mmu_en,
    output logic          align_chk_en,
    output logic          dcache_en,
    output logic          wbuf_en,
    output logic          big_endian,
    output logic          perm_s,
    output logic          perm_r,
    output logic          icache_en,
    output logic          rr_replace,
    output logic [DW-1:0] vec_base,
    output logic [1:0]    bus_mode
);
    logic [1:0] mode_field;
    logic [1:0] mode_hold_q;
    logic       ctrl_unused;

    assign ctrl_unused = ^{ctrl[29:15], ctrl[11:10], ctrl[6:4]};

    // Purpose: map single control bits to their enables
    always_comb begin
        mmu_en       = ctrl[B_MMU];
        align_chk_en = ctrl[B_ALIGN];
        dcache_en    = ctrl[B_DC];
        wbuf_en      = ctrl[B_WB];
        big_endian   = ctrl[B_BIG];
        perm_s       = ctrl[B_S];
        perm_r       = ctrl[B_R];
        icache_en    = ctrl[B_IC];
        rr_replace   = ctrl[B_RR];
        vec_base     = ctrl[B_VEC] ? DW'(VEC_HI) : '0;
    end

    assign mode_field = ctrl[B_MODE+1:B_MODE];

    // Purpose: substitute the last valid mode while the field is reserved
    always_comb begin
        bus_mode = (mode_field == MODE_RSVD) ? mode_hold_q : mode_field;
    end

    // Purpose: remember the mode currently driven
    always_ff @(posedge clk) begin
        if (!rst_n) mode_hold_q <= 2'b00;
        else        mode_hold_q <= bus_mode;
    end

    a_r7_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode != MODE_RSVD);
endmodule

// File: rtl/sysctl_cop.sv
// System control coprocessor register bank (top).
// Decodes move-to / move-from transfers, holds the registers and drives
// decoded control outputs. Assumes at most one transfer per cycle.
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int          DW         = 32,
    parameter logic [31:0] DEV_ID     = 32'h4112_9200,
    parameter logic [31:0] CACHE_TYPE = 32'h0D17_2172,
    parameter logic [31:0] CTRL_MASK  = 32'hC000_738F,
    parameter logic [31:0] VEC_HI     = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_valid,
    input  logic          xfer_wr,
    input  logic [2:0]    op1,
    input  logic [3:0]    crn,
    input  logic [3:0]    crm,
    input  logic [2:0]    op2,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          undef_flag,
    output logic          mmu_en,
    output logic          align_chk_en,
    output logic          dcache_en,
    output logic          wbuf_en,
    output logic          big_endian,
    output logic          perm_s,
    output logic          perm_r,
    output logic          icache_en,
    output logic          rr_replace,
    output logic [DW-1:0] vec_base,
    output logic [1:0]    bus_mode,
    output logic [DW-1:0] ttb_base,
    output logic [DW-1:0] domain_acc
);
    reg_sel_e      sel;
    logic          illegal;
    logic          wr_en;
    logic [DW-1:0] ctrl_q;

    sysctl_decode u_decode (
        .op1 (op1),
        .crn (crn),
        .crm (crm),
        .op2 (op2),
        .sel (sel)
    );

    assign wr_en = xfer_valid && xfer_wr;

    sysctl_regs #(.DW(DW), .CTRL_MASK(CTRL_MASK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .ttb_q  (ttb_base),
        .dac_q  (domain_acc)
    );

    sysctl_ctrl_out #(.DW(DW), .VEC_HI(VEC_HI)) u_ctrl_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl_q),
        .mmu_en       (mmu_en),
        .align_chk_en (align_chk_en),
        .dcache_en    (dcache_en),
        .wbuf_en      (wbuf_en),
        .big_endian   (big_endian),
        .perm_s       (perm_s),
        .perm_r       (perm_r),
        .icache_en    (icache_en),
        .rr_replace   (rr_replace),
        .vec_base     (vec_base),
        .bus_mode     (bus_mode)
    );

    // Purpose: classify a request as undefined (unknown entry or read-only write)
    always_comb begin
        illegal = xfer_valid &&
                  (sel == SEL_NONE || (xfer_wr && (sel == SEL_ID || sel == SEL_CTYPE)));
    end

    // Purpose: combinational read mux with its strobe
    always_comb begin
        rvalid = xfer_valid && !xfer_wr && sel != SEL_NONE;
        rdata  = '0;
        if (rvalid) begin
            unique case (sel)
                SEL_ID:    rdata = DW'(DEV_ID);
                SEL_CTYPE: rdata = DW'(CACHE_TYPE);
                SEL_CTRL:  rdata = ctrl_q;
                SEL_TTB:   rdata = ttb_base;
                SEL_DAC:   rdata = domain_acc;
                default:   rdata = '0;
            endcase
        end
    end

    // Purpose: register the undefined-access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) undef_flag <= 1'b0;
        else        undef_flag <= illegal;
    end

    a_r1_undef_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> undef_flag);
    a_r1_quiet_after_good: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal |=> !undef_flag);
    a_r10_rvalid_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (xfer_valid && !xfer_wr));
    a_r2_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && crn == 4'd0 && op2 == 3'd0) |-> rdata == DW'(DEV_ID));
endmodule

// File: tb/sysctl_cop_tb.sv
module sysctl_cop_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'hC000_738F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xfer_valid, xfer_wr;
    logic [2:0]  op1, op2;
    logic [3:0]  crn, crm;
    logic [31:0] wdata;
    logic [31:0] rdata, vec_base, ttb_base, domain_acc;
    logic        rvalid, undef_flag, mmu_en, align_chk_en, dcache_en, wbuf_en;
    logic        big_endian, perm_s, perm_r, icache_en, rr_replace;
    logic [1:0]  bus_mode;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_ctrl, m_ttb, m_dac;
    logic [1:0]  m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cop u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_wr(xfer_wr),
        .op1(op1), .crn(crn), .crm(crm), .op2(op2), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .undef_flag(undef_flag),
        .mmu_en(mmu_en), .align_chk_en(align_chk_en), .dcache_en(dcache_en),
        .wbuf_en(wbuf_en), .big_endian(big_endian), .perm_s(perm_s),
        .perm_r(perm_r), .icache_en(icache_en), .rr_replace(rr_replace),
        .vec_base(vec_base), .bus_mode(bus_mode), .ttb_base(ttb_base),
        .domain_acc(domain_acc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit legal(input logic [2:0] o1, input logic [3:0] n,
                                 input logic [3:0] m, input logic [2:0] o2);
        if (o1 != 0 || m != 0) return 0;
        if (n == 0) return o2 < 2;
        return (n >= 1 && n <= 3) && o2 == 0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] n, input logic [2:0] o2);
        case (n)
            4'd0:    return (o2 == 0) ? 32'h4112_9200 : 32'h0D17_2172;
            4'd1:    return m_ctrl;
            4'd2:    return m_ttb;
            default: return m_dac;
        endcase
    endfunction

    // R4 R6 R7 R8 R9: compare every decoded output with the model
    task automatic check_outs();
        check("R6 mmu_en",     {31'd0, mmu_en},       {31'd0, m_ctrl[0]});
        check("R6 align",      {31'd0, align_chk_en}, {31'd0, m_ctrl[1]});
        check("R6 dcache",     {31'd0, dcache_en},    {31'd0, m_ctrl[2]});
        check("R6 wbuf",       {31'd0, wbuf_en},      {31'd0, m_ctrl[3]});
        check("R6 big_endian", {31'd0, big_endian},   {31'd0, m_ctrl[7]});
        check("R6 perm_s",     {31'd0, perm_s},       {31'd0, m_ctrl[8]});
        check("R6 perm_r",     {31'd0, perm_r},       {31'd0, m_ctrl[9]});
        check("R6 icache",     {31'd0, icache_en},    {31'd0, m_ctrl[12]});
        check("R6 rr_replace", {31'd0, rr_replace},   {31'd0, m_ctrl[14]});
        check("R6 vec_base",   vec_base, m_ctrl[13] ? 32'hFFFF_0000 : 32'h0);
        check("R7 bus_mode",   {30'd0, bus_mode},     {30'd0, m_mode});
        check("R8 ttb_base",   ttb_base, m_ttb);
        check("R9 domain_acc", domain_acc, m_dac);
    endtask

    // One transfer: driven at a falling edge, read checked in the same cycle,
    // flag and outputs checked one cycle later (R1 R10)
    task automatic xfer(input bit wr, input logic [2:0] o1, input logic [3:0] n,
                        input logic [3:0] m, input logic [2:0] o2, input logic [31:0] d);
        bit ok;
        ok = legal(o1, n, m, o2);
        xfer_valid = 1; xfer_wr = wr; op1 = o1; crn = n; crm = m; op2 = o2; wdata = d;
        #1;
        check("R10 rvalid", {31'd0, rvalid}, {31'd0, (!wr && ok)});
        if (!wr && ok) check("R2 R5 R10 read data", rdata, exp_read(n, o2));
        @(negedge clk);
        if (wr && ok && n != 0) begin
            if (n == 1) begin
                m_ctrl = d & MASK;
                if (d[31:30] != 2'b10) m_mode = d[31:30];
            end else if (n == 2) m_ttb = d;
            else m_dac = d;
        end
        check("R1 R3 undef_flag", {31'd0, undef_flag},
              {31'd0, (!ok || (wr && n == 0))});
        check_outs();
        xfer_valid = 0; xfer_wr = 0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        rst_n = 0; xfer_valid = 0; xfer_wr = 0;
        op1 = 0; crn = 0; crm = 0; op2 = 0; wdata = 0;
        m_ctrl = 0; m_ttb = 0; m_dac = 0; m_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state
        check("R4 undef idle", {31'd0, undef_flag}, 32'd0);
        check_outs();
        // R2 identity entries
        xfer(0, 0, 0, 0, 0, 0);
        xfer(0, 0, 0, 0, 1, 0);
        xfer(0, 0, 0, 0, 2, 0);            // R1 undefined op2
        // R3 writes to read-only entries ignored
        xfer(1, 0, 2, 0, 0, 32'h3000_0000);
        xfer(1, 0, 0, 0, 0, 32'hFFFF_FFFF);
        xfer(1, 0, 0, 0, 1, 32'hFFFF_FFFF);
        xfer(0, 0, 0, 0, 0, 0);
        xfer(0, 0, 2, 0, 0, 0);            // R8 readback
        // R5 mask
        xfer(1, 0, 1, 0, 0, 32'hFFFF_FFFF);
        xfer(0, 0, 1, 0, 0, 0);
        // R5 read-modify-write of bit 0
        xfer(1, 0, 1, 0, 0, 32'h0000_2000);
        xfer(0, 0, 1, 0, 0, 0);
        xfer(1, 0, 1, 0, 0, rdata_last() | 32'h1);
        xfer(0, 0, 1, 0, 0, 0);
        // R7 bus mode with reserved code
        xfer(1, 0, 1, 0, 0, 32'h4000_0000);
        xfer(1, 0, 1, 0, 0, 32'h8000_0000);
        xfer(0, 0, 1, 0, 0, 0);
        xfer(1, 0, 1, 0, 0, 32'hC000_0000);
        xfer(1, 0, 1, 0, 0, 32'h8000_0001);
        xfer(1, 0, 1, 0, 0, 32'h0000_0000);
        xfer(1, 0, 1, 0, 0, 32'h8000_0000);
        // R9 domain word
        xfer(1, 0, 3, 0, 0, 32'hFFFF_FFFF);
        xfer(0, 0, 3, 0, 0, 0);
        // R1 bad op1 / crm / crn, writes must not land
        xfer(1, 1, 1, 0, 0, 32'h0000_0001);
        xfer(1, 0, 2, 5, 0, 32'h1234_5678);
        xfer(1, 0, 7, 0, 0, 32'h1234_5678);
        xfer(0, 0, 15, 0, 0, 0);
        // Constrained random mix
        for (int i = 0; i < 800; i++) begin
            logic [2:0] o1, o2;
            logic [3:0] n, m;
            o1 = ($urandom % 10 == 0) ? 3'($urandom) : 3'd0;
            m  = ($urandom % 10 == 0) ? 4'($urandom) : 4'd0;
            n  = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
            o2 = ($urandom % 6 == 0) ? 3'($urandom) : 3'($urandom % 2);
            xfer(1'($urandom), o1, n, m, o2, $urandom);
            if ($urandom % 4 == 0) @(negedge clk);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [31:0] rdata_last();
        return m_ctrl;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule